// File: doc/BRIEF.md
# Flag-Paced Character I/O Port

This block sits between an accumulator-style processor and two character devices: a keyboard that supplies characters and a printer that consumes them. Each direction owns one character holding register and one ready flag. The keyboard side fills the input holding register and raises the input flag. The processor empties it with an input-character operation. The output side works the other way round. Its flag starts set, the processor's output-character operation clears it, and the printer sets it again when it has finished printing the character.

The processor drives a six-bit one-hot operation word, normally wired from bits 11 down to 6 of the instruction. It also supplies the low byte of its accumulator. In return it receives the held input character, a one-cycle skip pulse and the interrupt-enable state. An interrupt request is raised whenever interrupts are enabled and either flag is set. A separate clear input lets the processor's interrupt cycle drop the enable.

Top module: `term_io_port`

## Requirements
- R1: After reset the input flag is 0 and the output flag is 1. So `kbd_ready_o`=1, and `rd_char_o`, `prn_char_o`, `prn_valid_o`, `skip_o`, `ien_o` and `irq_o` are all 0.
- R2: When `kbd_valid_i` and `kbd_ready_o` are both 1 at a clock edge, `rd_char_o` shows `kbd_char_i` after that edge and the input flag is set, so `kbd_ready_o` reads 0.
- R3: While the input flag is 1, `kbd_ready_o` is 0 and characters offered on the keyboard port leave `rd_char_o` unchanged.
- R4: The input-character operation (`io_cmd_i` bit 5) clears the input flag at the edge, so `kbd_ready_o` returns to 1. `rd_char_o` keeps its value. A keyboard handshake in the same cycle wins and leaves the flag set.
- R5: The output-character operation (bit 4) issued while the output flag is 1 loads `prn_char_o` from `acc_lo_i`, clears the output flag, and raises `prn_valid_o` for exactly one cycle after the edge.
- R6: While the output flag is 0, an output-character operation has no effect: `prn_char_o` holds and no `prn_valid_o` pulse occurs. A `prn_done_i` pulse sets the output flag again.
- R7: Skip-on-input (bit 3) makes `skip_o` 1 for the one cycle after the edge only if the input flag was 1. Otherwise `skip_o` stays 0.
- R8: Skip-on-output (bit 2) makes `skip_o` 1 for the one cycle after the edge only if the output flag was 1. Otherwise `skip_o` stays 0.
- R9: Enable-on (bit 1) sets `ien_o` and enable-off (bit 0) clears it, visible after the edge.
- R10: `int_clr_i` clears `ien_o` at the edge and takes priority over an enable-on in the same cycle.
- R11: `irq_o` equals `ien_o` AND (input flag OR output flag) at all times.
- R12: An `io_cmd_i` value with zero or more than one bit set performs no operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_char_i | input | CHAR_W | Character offered by the keyboard |
| kbd_valid_i | input | 1 | Keyboard has a character to offer |
| kbd_ready_o | output | 1 | Input register is free (input flag is 0) |
| prn_char_o | output | CHAR_W | Character held for the printer |
| prn_valid_o | output | 1 | One-cycle pulse when a new character is loaded for printing |
| prn_done_i | input | 1 | Printer finished the current character |
| io_cmd_i | input | 6 | One-hot operation: 5 input-char, 4 output-char, 3 skip-input, 2 skip-output, 1 enable-on, 0 enable-off |
| acc_lo_i | input | CHAR_W | Low byte of the accumulator |
| int_clr_i | input | 1 | Interrupt-cycle clear of the enable |
| rd_char_o | output | CHAR_W | Held input character for the accumulator |
| skip_o | output | 1 | Skip request pulse |
| ien_o | output | 1 | Interrupt enable state |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the collisions. A keyboard handshake can land in the same edge as an input-character operation. A printer done pulse can meet an output-character operation while the output flag is still clear. An interrupt-cycle clear can coincide with enable-on. Each of these shows up only in the flag state that precedes it. The bench drives a long pseudo-random sweep that sets keyboard, printer, clear and every one-hot or malformed operation word independently each cycle, so all flag combinations and collisions occur many times. A reference model built from the requirements predicts every output after every edge. Directed sequences in front of the sweep pin down the exact ordering cases.

// File: rtl/term_io_pkg.sv
package term_io_pkg;

    // Number of one-hot I/O operation bits.
    localparam int NUM_OPS = 6;

    // Decoded operations; member order matches io_cmd_i bit order (MSB first).
    typedef struct packed {
        logic inp;   // take input character
        logic outc;  // send output character
        logic ski;   // skip if input flag set
        logic sko;   // skip if output flag set
        logic ion;   // enable interrupts
        logic iof;   // disable interrupts
    } io_ops_t;

endpackage

// File: rtl/io_cmd_decode.sv
module io_cmd_decode
    import term_io_pkg::*;
(
    input  logic [NUM_OPS-1:0] cmd_i,
    output io_ops_t            ops_o
);

    logic cmd_ok;

    always_comb begin
        cmd_ok = $onehot(cmd_i);
        ops_o  = cmd_ok ? io_ops_t'(cmd_i) : '0;
    end

endmodule

// File: rtl/kbd_channel.sv
module kbd_channel #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] kbd_char_i,
    input  logic              kbd_valid_i,
    output logic              kbd_ready_o,
    input  logic              take_i,
    output logic [CHAR_W-1:0] char_o,
    output logic              flag_o
);

    typedef struct packed {
        logic              flag;
        logic [CHAR_W-1:0] data;
    } kbd_state_t;

    kbd_state_t st_q, st_d;
    logic       accept;

    always_comb begin
        st_d   = st_q;
        accept = kbd_valid_i & ~st_q.flag;
        if (take_i) begin
            st_d.flag = 1'b0;
        end
        if (accept) begin
            st_d.data = kbd_char_i;
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign kbd_ready_o = ~st_q.flag;
    assign char_o      = st_q.data;
    assign flag_o      = st_q.flag;

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_valid_i && kbd_ready_o) |=> (flag_o && char_o == $past(kbd_char_i)));

    assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o |=> $stable(char_o));

endmodule

// File: rtl/prn_channel.sv
module prn_channel #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_i,
    input  logic [CHAR_W-1:0] acc_i,
    input  logic              done_i,
    output logic [CHAR_W-1:0] prn_char_o,
    output logic              prn_valid_o,
    output logic              flag_o
);

    typedef struct packed {
        logic              flag;
        logic              valid;
        logic [CHAR_W-1:0] data;
    } prn_state_t;

    prn_state_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (done_i) begin
            st_d.flag = 1'b1;
        end
        if (send_i && st_q.flag) begin
            st_d.data  = acc_i;
            st_d.flag  = 1'b0;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.flag <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign prn_char_o  = st_q.data;
    assign prn_valid_o = st_q.valid;
    assign flag_o      = st_q.flag;

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prn_valid_o |=> !prn_valid_o);

    assert_hold_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !done_i) |=> ($stable(prn_char_o) && !prn_valid_o && !flag_o));

endmodule

// File: rtl/io_ctrl.sv
module io_ctrl
    import term_io_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  io_ops_t ops_i,
    input  logic    fgi_i,
    input  logic    fgo_i,
    input  logic    int_clr_i,
    output logic    skip_o,
    output logic    ien_o,
    output logic    irq_o
);

    typedef struct packed {
        logic skip;
        logic ien;
    } ctrl_state_t;

    ctrl_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.skip = (ops_i.ski & fgi_i) | (ops_i.sko & fgo_i);
        if (ops_i.ion) begin
            st_d.ien = 1'b1;
        end
        if (ops_i.iof || int_clr_i) begin
            st_d.ien = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign skip_o = st_q.skip;
    assign ien_o  = st_q.ien;
    assign irq_o  = st_q.ien & (fgi_i | fgo_i);

    assert_skip_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ops_i.ski && !fgi_i) |=> !skip_o);

    assert_skip_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ops_i.sko && !fgo_i) |=> !skip_o);

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int_clr_i |=> !ien_o);

    assert_enable_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ops_i.ion && !int_clr_i) |=> ien_o);

endmodule

// File: rtl/term_io_port.sv
module term_io_port
    import term_io_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] kbd_char_i,
    input  logic              kbd_valid_i,
    output logic              kbd_ready_o,
    output logic [CHAR_W-1:0] prn_char_o,
    output logic              prn_valid_o,
    input  logic              prn_done_i,
    input  logic [5:0]        io_cmd_i,
    input  logic [CHAR_W-1:0] acc_lo_i,
    input  logic              int_clr_i,
    output logic [CHAR_W-1:0] rd_char_o,
    output logic              skip_o,
    output logic              ien_o,
    output logic              irq_o
);

    io_ops_t ops;
    logic    fgi;
    logic    fgo;

    io_cmd_decode u_decode (
        .cmd_i (io_cmd_i),
        .ops_o (ops)
    );

    kbd_channel #(.CHAR_W(CHAR_W)) u_kbd (
        .clk         (clk),
        .rst_n       (rst_n),
        .kbd_char_i  (kbd_char_i),
        .kbd_valid_i (kbd_valid_i),
        .kbd_ready_o (kbd_ready_o),
        .take_i      (ops.inp),
        .char_o      (rd_char_o),
        .flag_o      (fgi)
    );

    prn_channel #(.CHAR_W(CHAR_W)) u_prn (
        .clk         (clk),
        .rst_n       (rst_n),
        .send_i      (ops.outc),
        .acc_i       (acc_lo_i),
        .done_i      (prn_done_i),
        .prn_char_o  (prn_char_o),
        .prn_valid_o (prn_valid_o),
        .flag_o      (fgo)
    );

    io_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ops_i     (ops),
        .fgi_i     (fgi),
        .fgo_i     (fgo),
        .int_clr_i (int_clr_i),
        .skip_o    (skip_o),
        .ien_o     (ien_o),
        .irq_o     (irq_o)
    );

    assert_irq_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ien_o && (!kbd_ready_o || fgo)));

endmodule

// File: tb/term_io_port_bench.sv
`timescale 1ns/1ps
module term_io_port_bench;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] kbd_char = '0;
    logic          kbd_valid = 1'b0;
    logic          kbd_ready;
    logic [CW-1:0] prn_char;
    logic          prn_valid;
    logic          prn_done = 1'b0;
    logic [5:0]    io_cmd = '0;
    logic [CW-1:0] acc_lo = '0;
    logic          int_clr = 1'b0;
    logic [CW-1:0] rd_char;
    logic          skip;
    logic          ien;
    logic          irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    bit            m_fgi, m_fgo, m_ien;
    logic [CW-1:0] m_inpr, m_outr;
    bit            e_skip, e_pv;

    always #2.5 clk = ~clk;

    term_io_port #(.CHAR_W(CW)) u_term_io_port (
        .clk(clk), .rst_n(rst_n),
        .kbd_char_i(kbd_char), .kbd_valid_i(kbd_valid), .kbd_ready_o(kbd_ready),
        .prn_char_o(prn_char), .prn_valid_o(prn_valid), .prn_done_i(prn_done),
        .io_cmd_i(io_cmd), .acc_lo_i(acc_lo), .int_clr_i(int_clr),
        .rd_char_o(rd_char), .skip_o(skip), .ien_o(ien), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus, step the model, then compare every output.
    task automatic cyc(input logic [5:0] cmd, input logic [CW-1:0] acc,
                       input bit kv, input logic [CW-1:0] kc,
                       input bit done, input bit clr);
        bit ok, inp, outc, ski, sko, ion, iof;
        io_cmd = cmd; acc_lo = acc; kbd_valid = kv; kbd_char = kc;
        prn_done = done; int_clr = clr;
        ok   = ($countones(cmd) == 1);
        inp  = ok & cmd[5]; outc = ok & cmd[4]; ski = ok & cmd[3];
        sko  = ok & cmd[2]; ion  = ok & cmd[1]; iof = ok & cmd[0];
        e_skip = (ski & m_fgi) | (sko & m_fgo);
        e_pv   = outc & m_fgo;
        @(posedge clk); #1;
        if (outc && m_fgo) begin m_outr = acc; m_fgo = 0; end
        else if (done) m_fgo = 1;
        if (kv && !m_fgi) begin m_inpr = kc; m_fgi = 1; end
        else if (inp) m_fgi = 0;
        if (clr || iof) m_ien = 0;
        else if (ion) m_ien = 1;
        chk("R2 rd_char", rd_char, m_inpr);
        chk("R3/R4 kbd_ready", kbd_ready, !m_fgi);
        chk("R6 prn_char", prn_char, m_outr);
        chk("R5 prn_valid", prn_valid, e_pv);
        chk("R7/R8 skip", skip, e_skip);
        chk("R9/R10 ien", ien, m_ien);
        chk("R11 irq", irq, m_ien & (m_fgi | m_fgo));
        io_cmd = '0; kbd_valid = 0; prn_done = 0; int_clr = 0;
    endtask

    initial begin
        logic [31:0] lfsr;
        m_fgi = 0; m_fgo = 1; m_ien = 0; m_inpr = '0; m_outr = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state while reset is held
        chk("R1 kbd_ready", kbd_ready, 1);
        chk("R1 rd_char", rd_char, 0);
        chk("R1 prn_char", prn_char, 0);
        chk("R1 prn_valid", prn_valid, 0);
        chk("R1 skip", skip, 0);
        chk("R1 ien", ien, 0);
        chk("R1 irq", irq, 0);
        rst_n = 1;
        cyc(6'b000100, 8'h00, 0, 8'h00, 0, 0);           // R8: output flag set at reset
        chk("R1 fgo via skip R8", skip, 1);
        cyc(6'b001000, 8'h00, 0, 8'h00, 0, 0);           // R7: input flag clear
        chk("R7 no skip", skip, 0);
        cyc(6'b000000, 8'h00, 1, 8'h5A, 0, 0);           // R2 accept
        chk("R2 char", rd_char, 8'h5A);
        chk("R2 ready low", kbd_ready, 0);
        repeat (3) cyc(6'b000000, 8'h00, 1, 8'hC3, 0, 0); // R3 blocked
        chk("R3 held", rd_char, 8'h5A);
        cyc(6'b001000, 8'h00, 0, 8'h00, 0, 0);
        chk("R7 skip", skip, 1);
        cyc(6'b000000, 8'h00, 0, 8'h00, 0, 0);
        chk("R7 one cycle", skip, 0);
        cyc(6'b100000, 8'h00, 0, 8'h00, 0, 0);           // R4 take
        chk("R4 ready", kbd_ready, 1);
        chk("R4 char kept", rd_char, 8'h5A);
        cyc(6'b100000, 8'h00, 1, 8'h21, 0, 0);           // R4 handshake wins
        chk("R4 collision", kbd_ready, 0);
        chk("R4 collision char", rd_char, 8'h21);
        cyc(6'b100000, 8'h00, 0, 8'h00, 0, 0);
        cyc(6'b010000, 8'h3C, 0, 8'h00, 0, 0);           // R5 send
        chk("R5 char", prn_char, 8'h3C);
        chk("R5 pulse", prn_valid, 1);
        cyc(6'b010000, 8'h77, 0, 8'h00, 0, 0);           // R6 ignored while busy
        chk("R6 ignored char", prn_char, 8'h3C);
        chk("R6 no pulse", prn_valid, 0);
        cyc(6'b000100, 8'h00, 0, 8'h00, 0, 0);
        chk("R8 busy no skip", skip, 0);
        cyc(6'b010000, 8'h99, 0, 8'h00, 1, 0);           // R6 done with ignored send
        chk("R6 send while busy still ignored", prn_char, 8'h3C);
        cyc(6'b000100, 8'h00, 0, 8'h00, 0, 0);
        chk("R6 done sets flag", skip, 1);
        cyc(6'b000010, 8'h00, 0, 8'h00, 0, 0);           // R9 on
        chk("R9 on", ien, 1);
        chk("R11 irq from fgo", irq, 1);
        cyc(6'b000001, 8'h00, 0, 8'h00, 0, 0);
        chk("R9 off", ien, 0);
        cyc(6'b000010, 8'h00, 0, 8'h00, 0, 1);           // R10 clear wins
        chk("R10 clear wins", ien, 0);
        cyc(6'b000010, 8'h00, 0, 8'h00, 0, 0);
        cyc(6'b100001, 8'h00, 0, 8'h00, 0, 0);           // R12 two bits
        chk("R12 multi-bit ignored", ien, 1);
        cyc(6'b110000, 8'h55, 0, 8'h00, 0, 0);
        chk("R12 no send", prn_valid, 0);
        cyc(6'b111111, 8'h55, 0, 8'h00, 0, 0);
        chk("R12 all-ones ignored", ien, 1);

        // Near-exhaustive pseudo-random sweep; model checks every output.
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 6000; i++) begin
            logic [5:0] c;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[2:0] < 3'd6) c = 6'b1 << lfsr[2:0];
            else if (lfsr[3])     c = lfsr[9:4];
            else                  c = '0;
            cyc(c, lfsr[31:24], lfsr[10], lfsr[23:16], lfsr[11] & lfsr[12], lfsr[13] & lfsr[14] & lfsr[15]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        finished = 1;
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog act=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule